// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-channel SPI master that software drives through three 16-bit registers: a data word, a control word and a status word. Writing the data word starts a serial exchange of one byte, or of two bytes back to back when the control word selects the wide mode. The bits returned by the slave during that exchange are gathered and placed in the data word, where a later read collects them. That read also retires the receive-full flag.

The serial side drives a clock, an output data line and an active-low select, and samples one input data line. The control word sets the clock rate through a 7-bit divider, the level at which the clock rests, and on which clock edge data is launched and captured. One level-sensitive interrupt line reports an idle engine, a waiting received word, or both, each under its own enable and under a master enable.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the data, control and status words all read zero, `csN` is high, `sclk` is low and `irq` is low.
- R2: The data word is at byte offset 0x0, control at 0x2 and status at 0x4; the control word reads back every bit written. Any other offset reads zero and ignores writes, and writes to the status word change nothing.
- R3: `busByteEn[0]` selects bits 7:0 and `busByteEn[1]` bits 15:8 of a write; an unselected byte keeps its previous register value (for the data word, the previous received value is the one sent).
- R4: Control bit 2 selects the width: 0 sends bits 7:0 of the written word, 1 sends bits 15:8 and then bits 7:0 with `csN` low across both bytes; each byte goes most significant bit first. In wide mode the first received byte lands in bits 15:8 of the data word; in byte mode bits 15:8 read zero.
- R5: With divider value D in control bits 15:9, every `sclk` half-period lasts D+1 clocks; `csN` falls D+1 clocks before the first `sclk` edge and rises D+1 clocks after the last; a byte takes 16 edges.
- R6: `sclk` rests at the level in control bit 8. With control bit 7 clear, `mosi` changes on each leading edge and `miso` is captured on each trailing edge; with bit 7 set, the first bit is on `mosi` when `csN` falls, `miso` is captured on each leading edge and `mosi` changes on each trailing edge.
- R7: Status bit 0 (busy) is high from the clock after a data write until the exchange ends; status bit 1 (receive full) becomes set in the same clock that busy falls and `csN` rises. A data write while busy is ignored.
- R8: Reading the data word returns the received value and clears receive full, so the status word then reads zero.
- R9: `irq` is low while control bit 0 is clear; otherwise it is high when (busy is low and control bit 6 is set) or (receive full is set and control bit 5 is set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| busValid | input | 1 | Bus access strobe for this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busByteEn | input | 2 | Byte lane enables for a write |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 1 | Active-low slave select |
| irq | output | 1 | Level interrupt |

## Verification
The exchange is swept over every combination of resting level and capture phase, both widths and four divider values, each with several transmit and slave-reply words chosen so that a reversed bit order, a swapped byte or a sample taken on the wrong edge changes the result. A slave model in the bench captures what it receives and times every `sclk` edge and `csN` change, which separates a wrong half-period from a wrong select setup or hold. The interrupt is swept over all enable combinations with the receive flag both set and clear and with the engine both busy and idle, and byte-lane writes are tried with each lane pattern on the control and data words.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W    = 16;
  localparam int DIV_W    = 7;
  localparam int MAX_BITS = 16;
  localparam int EDGE_W   = $clog2(2 * MAX_BITS);

  // byte offsets of the three words
  localparam int OFF_DATA = 0;
  localparam int OFF_CTRL = 2;
  localparam int OFF_STAT = 4;

  // control word field positions
  localparam int CTL_EN      = 0;
  localparam int CTL_WIDE    = 2;
  localparam int CTL_RXIE    = 5;
  localparam int CTL_DONEIE  = 6;
  localparam int CTL_PHASE   = 7;
  localparam int CTL_IDLE    = 8;
  localparam int CTL_DIV_LSB = 9;

  // status word field positions
  localparam int STAT_BUSY = 0;
  localparam int STAT_RBF  = 1;

  typedef struct packed {
    logic load;    // capture the word to send
    logic lead;    // sclk leaves its resting level
    logic trail;   // sclk returns to its resting level
    logic finish;  // exchange over, commit received word
  } spimStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wide,
  input  logic [DIV_W-1:0]  div,
  output spimStrobe_t       strb,
  output logic              busy,
  output logic              csN
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} spimState_t;

  localparam logic [EDGE_W-1:0] LAST_WIDE = EDGE_W'(2 * MAX_BITS - 1);
  localparam logic [EDGE_W-1:0] LAST_BYTE = EDGE_W'(MAX_BITS - 1);

  spimState_t        state;
  logic [DIV_W-1:0]  halfCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] lastEdge;
  logic              tick;

  assign tick     = (state != ST_IDLE) && (halfCnt == div);
  assign lastEdge = wide ? LAST_WIDE : LAST_BYTE;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb        = '0;
    strb.load   = start && (state == ST_IDLE);
    strb.lead   = (state == ST_RUN) && tick && !edgeCnt[0];
    strb.trail  = (state == ST_RUN) && tick &&  edgeCnt[0];
    strb.finish = (state == ST_HOLD) && tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      edgeCnt <= '0;
      csN     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            halfCnt <= '0;
            edgeCnt <= '0;
            csN     <= 1'b0;
          end
        end
        ST_RUN: begin
          halfCnt <= tick ? '0 : halfCnt + 1'b1;
          if (tick) begin
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == lastEdge) state <= ST_HOLD;
          end
        end
        default: begin
          halfCnt <= tick ? '0 : halfCnt + 1'b1;
          if (tick) begin
            state <= ST_IDLE;
            csN   <= 1'b1;
          end
        end
      endcase
    end
  end

  // R7
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !csN));

  // R5
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busByteEn,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  spimStrobe_t       strb,
  input  logic              busy,
  input  logic              csN,
  input  logic              miso,
  output logic              start,
  output logic              wideQ,
  output logic [DIV_W-1:0]  div,
  output logic              sclk,
  output logic              mosi,
  output logic              irq
);
  localparam int HALF_W = REG_W / 2;

  logic [REG_W-1:0] dataQ, ctrlQ, txSr, rxSr, laneMask, txWord, loadVal, statWord;
  logic             rbfQ, sclkQ, mosiQ;
  logic             selData, selCtrl, selStat, rdData, wrCtrl, phase, idleLvl;

  assign selData = busValid && (busAddr == ADDR_W'(OFF_DATA));
  assign selCtrl = busValid && (busAddr == ADDR_W'(OFF_CTRL));
  assign selStat = busValid && (busAddr == ADDR_W'(OFF_STAT));
  assign rdData  = selData && !busWrite;
  assign wrCtrl  = selCtrl && busWrite;
  assign start   = selData && busWrite && !busy;

  assign laneMask = {{HALF_W{busByteEn[1]}}, {HALF_W{busByteEn[0]}}};
  assign txWord   = (busWdata & laneMask) | (dataQ & ~laneMask);
  assign loadVal  = ctrlQ[CTL_WIDE] ? txWord : {txWord[HALF_W-1:0], {HALF_W{1'b0}}};

  assign div     = ctrlQ[CTL_DIV_LSB +: DIV_W];
  assign phase   = ctrlQ[CTL_PHASE];
  assign idleLvl = ctrlQ[CTL_IDLE];

  always_comb begin
    statWord            = '0;
    statWord[STAT_BUSY] = busy;
    statWord[STAT_RBF]  = rbfQ;
  end

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      if (selData)      busRdata = dataQ;
      else if (selCtrl) busRdata = ctrlQ;
      else if (selStat) busRdata = statWord;
    end
  end

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      dataQ <= '0;
      rbfQ  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= (busWdata & laneMask) | (ctrlQ & ~laneMask);
      if (strb.finish) begin
        dataQ <= wideQ ? rxSr : {{HALF_W{1'b0}}, rxSr[HALF_W-1:0]};
        rbfQ  <= 1'b1;
      end else if (rdData) begin
        rbfQ  <= 1'b0;
      end
    end
  end

  // shift engine and serial pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr  <= '0;
      rxSr  <= '0;
      wideQ <= 1'b0;
      sclkQ <= 1'b0;
      mosiQ <= 1'b0;
    end else begin
      if (strb.load) begin
        wideQ <= ctrlQ[CTL_WIDE];
        rxSr  <= '0;
        if (phase) begin
          mosiQ <= loadVal[REG_W-1];
          txSr  <= loadVal << 1;
        end else begin
          txSr  <= loadVal;
        end
      end
      if (strb.lead || strb.trail) sclkQ <= ~sclkQ;
      else if (!busy)              sclkQ <= idleLvl;
      if ((strb.lead && !phase) || (strb.trail && phase)) begin
        mosiQ <= txSr[REG_W-1];
        txSr  <= txSr << 1;
      end
      if ((strb.trail && !phase) || (strb.lead && phase))
        rxSr <= {rxSr[REG_W-2:0], miso};
    end
  end

  assign sclk = sclkQ;
  assign mosi = mosiQ;
  assign irq  = ctrlQ[CTL_EN] &&
                ((!busy && ctrlQ[CTL_DONEIE]) || (rbfQ && ctrlQ[CTL_RXIE]));

  // R8
  rbf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !strb.finish) |=> !rbfQ);

  // R7
  done_sets_rbf_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (rbfQ && !busy && csN));

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $stable(idleLvl)) |-> (sclk == idleLvl));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spim_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busByteEn,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN,
  output logic              irq
);
  spimStrobe_t      strb;
  logic             busy, start, wideQ;
  logic [DIV_W-1:0] div;

  spim_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .wide  (wideQ),
    .div   (div),
    .strb  (strb),
    .busy  (busy),
    .csN   (csN)
  );

  spim_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .strb      (strb),
    .busy      (busy),
    .csN       (csN),
    .miso      (miso),
    .start     (start),
    .wideQ     (wideQ),
    .div       (div),
    .sclk      (sclk),
    .mosi      (mosi),
    .irq       (irq)
  );
endmodule

// File: tb/spi_reg_master_tb.sv
module spi_reg_master_tb;
  localparam int ADDR_W = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [1:0] busByteEn = 2'b00;
  logic [15:0] busWdata = '0, busRdata;
  logic sclk, mosi, miso, csN, irq;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_reg_master #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csN(csN), .irq(irq));

  // ---------------- slave model ----------------
  logic [15:0] sTx = '0, sRx = '0;
  bit sPhase = 0, sIdle = 0, sActive = 0;
  int sBits = 8, sIdx = 0, sEdges = 0, sCsFalls = 0, sTimingBad = 0, sHalf = 10;
  time tLast = 0;

  initial miso = 1'b0;

  always @(negedge csN) begin
    sActive = 1; sIdx = 0; sEdges = 0; sRx = '0; tLast = $time; sCsFalls++;
    if (sPhase) miso = sTx[sBits-1];
  end

  always @(posedge csN) begin
    if (sActive) begin
      if ($time - tLast != sHalf) sTimingBad++;
      sActive = 0;
    end
  end

  always @(sclk) begin
    if (sActive && csN === 1'b0) begin
      if ($time - tLast != sHalf) sTimingBad++;
      tLast = $time;
      sEdges++;
      if (sclk != sIdle) begin          // leading edge
        if (!sPhase) begin
          if (sIdx < sBits) miso = sTx[sBits-1-sIdx];
        end else sRx = {sRx[14:0], mosi};
      end else begin                    // trailing edge
        if (!sPhase) begin
          sRx = {sRx[14:0], mosi};
          sIdx++;
        end else begin
          sIdx++;
          if (sIdx < sBits) miso = sTx[sBits-1-sIdx];
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input int addr, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = ADDR_W'(addr); busWdata = d; busByteEn = be;
    @(negedge clk);
    busValid = 0; busWrite = 0; busByteEn = 2'b00;
  endtask

  task automatic busRd(input int addr, output logic [15:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = ADDR_W'(addr);
    #1 d = busRdata;
    @(negedge clk);
    busValid = 0;
  endtask

  function automatic logic [15:0] mkCtrl(input int dv, input bit idle, input bit ph,
                                         input bit wide, input bit en, input bit rxie,
                                         input bit doneie);
    return (16'(dv) << 9) | (16'(idle) << 8) | (16'(ph) << 7) | (16'(doneie) << 6) |
           (16'(rxie) << 5) | (16'(wide) << 2) | 16'(en);
  endfunction

  task automatic waitIdle();
    logic [15:0] st;
    for (int k = 0; k < 3000; k++) begin
      busRd(4, st);
      if (st[0] == 1'b0) break;
    end
  endtask

  logic [15:0] lastRx = '0;

  // one complete exchange with all per-exchange checks
  task automatic xfer(input int dv, input bit idle, input bit ph, input bit wide,
                      input logic [15:0] wd, input logic [1:0] be, input logic [15:0] reply);
    logic [15:0] rd, sent, expRd;
    busWr(2, mkCtrl(dv, idle, ph, wide, 0, 0, 0));
    sPhase = ph; sIdle = idle; sBits = wide ? 16 : 8; sHalf = (dv + 1) * 10;
    sTx = reply; sTimingBad = 0; sCsFalls = 0;
    sent  = ({wd[15:8] & {8{be[1]}}, wd[7:0] & {8{be[0]}}}) |
            ({lastRx[15:8] & {8{~be[1]}}, lastRx[7:0] & {8{~be[0]}}});
    expRd = wide ? reply : {8'h00, reply[7:0]};
    busWr(0, wd, be);
    #1 chk("R7 busy after write", {15'd0, csN}, 16'd0);
    busRd(4, rd);
    chk("R7 status busy", rd, 16'h0001);
    waitIdle();
    chk("R4 slave received", wide ? sRx : {8'h00, sRx[7:0]}, wide ? sent : {8'h00, sent[7:0]});
    chk("R5 edge count", 16'(sEdges), wide ? 16'd32 : 16'd16);
    chk("R5 half-period and select timing", 16'(sTimingBad), 16'd0);
    chk("R6 sclk rests at idle level", {15'd0, sclk}, {15'd0, idle});
    busRd(4, rd);
    chk("R7 status after exchange", rd, 16'h0002);
    busRd(0, rd);
    chk("R4 received word", rd, expRd);
    busRd(4, rd);
    chk("R8 status after data read", rd, 16'h0000);
    lastRx = expRd;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] rd;
    int dvs[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 csN", {15'd0, csN}, 16'd1);
    chk("R1 sclk", {15'd0, sclk}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rstN = 1'b1;
    busRd(0, rd); chk("R1 data", rd, 16'h0000);
    busRd(2, rd); chk("R1 ctrl", rd, 16'h0000);
    busRd(4, rd); chk("R1 status", rd, 16'h0000);

    // R2 map and read-only status, R3 byte lanes on control
    busWr(2, 16'hFFF8);
    busRd(2, rd); chk("R2 ctrl readback", rd, 16'hFFF8);
    busWr(2, 16'h0000, 2'b01);
    busRd(2, rd); chk("R3 low lane only", rd, 16'hFF00);
    busWr(2, 16'h1234, 2'b10);
    busRd(2, rd); chk("R3 high lane only", rd, 16'h1200);
    busWr(2, 16'hAAAA, 2'b00);
    busRd(2, rd); chk("R3 no lane", rd, 16'h1200);
    busWr(4, 16'hFFFF);
    busRd(4, rd); chk("R2 status write ignored", rd, 16'h0000);
    foreach (dvs[i]) begin
      int a = (i == 0) ? 6 : (i == 1) ? 8 : (i == 2) ? 14 : 1;
      busWr(a, 16'hBEEF);
      busRd(a, rd); chk("R2 unmapped reads zero", rd, 16'h0000);
    end
    busRd(2, rd); chk("R2 ctrl untouched by unmapped writes", rd, 16'h1200);
    #1 chk("R2 no exchange from unmapped write", {15'd0, csN}, 16'd1);

    // R4 R5 R6 sweep
    for (int d = 0; d < 4; d++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          for (int p = 0; p < 3; p++) begin
            logic [15:0] wd, rp;
            wd = (p == 0) ? 16'hA55A : (p == 1) ? 16'h8001 ^ 16'(d * 4 + m) : 16'h1234 * 16'(m + 3);
            rp = ~({wd[7:0], wd[15:8]}) ^ 16'(p * 257 + d);
            xfer(dvs[d], m[1], m[0], w[0], wd, 2'b11, rp);
          end

    // R3 byte lanes on the data word: unselected lane sends the last received byte
    xfer(1, 0, 0, 1, 16'h005A, 2'b01, 16'hC3E1);
    xfer(0, 1, 1, 1, 16'h7700, 2'b10, 16'h0F0F);

    // R7 write while busy ignored
    busWr(2, mkCtrl(4, 0, 0, 1, 0, 0, 0));
    sPhase = 0; sIdle = 0; sBits = 16; sHalf = 50; sTx = 16'h1111; sCsFalls = 0; sTimingBad = 0;
    busWr(0, 16'h3C3C);
    busWr(0, 16'hFFFF);
    waitIdle();
    repeat (20) @(negedge clk);
    chk("R7 single exchange", 16'(sCsFalls), 16'd1);
    chk("R7 second write dropped", sRx, 16'h3C3C);
    busRd(0, rd); chk("R7 data from first exchange", rd, 16'h1111);
    lastRx = rd;

    // R9 interrupt sweep, receive full clear then set
    for (int r = 0; r < 2; r++) begin
      if (r == 1) begin
        busWr(2, mkCtrl(0, 0, 0, 0, 0, 0, 0));
        sBits = 8; sHalf = 10; sTx = 16'h0055;
        busWr(0, 16'h0011);
        waitIdle();
      end
      for (int e = 0; e < 8; e++) begin
        bit exp;
        busWr(2, mkCtrl(0, 0, 0, 0, e[0], e[1], e[2]));
        exp = e[0] && (e[2] || (r == 1 && e[1]));
        @(negedge clk);
        chk("R9 irq", {15'd0, irq}, {15'd0, exp});
      end
    end
    busRd(0, rd);
    // busy blocks the done term
    busWr(2, mkCtrl(20, 0, 0, 1, 1, 0, 1));
    @(negedge clk); chk("R9 irq idle done", {15'd0, irq}, 16'd1);
    sBits = 16; sHalf = 210; sTx = 16'h0000;
    busWr(0, 16'h0000);
    repeat (10) @(negedge clk);
    chk("R9 irq low while busy", {15'd0, irq}, 16'd0);
    waitIdle();
    @(negedge clk); chk("R9 irq after exchange", {15'd0, irq}, 16'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog all R actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule